// File: doc/BRIEF.md
# Oversampled SPI Slave Receiver

This block receives serial data as an SPI slave without ever using the SPI clock as a clock. The chip-select, serial-clock and data-in pins are treated as plain inputs. Each passes through a synchronizer running on the system clock, and a rising edge of the sampled serial clock shifts in one data bit. Every eight bits, most significant first, form one byte. That byte is presented on a valid/ready output stream.

The shifter is armed the whole time chip-select is deasserted. A transfer that starts clocking half a serial-clock period after chip-select falls therefore loses no edge. Clock activity on the bus while chip-select is deasserted can come from a master that is still starting up. It never shifts data. While chip-select is high and the sampled clock is also high, the bit counter and the shift register are cleared. A one-cycle pulse marks each falling edge of chip-select.

Back-pressure: the output holds a single byte. While `rx_valid` is high and `rx_ready` is low, `rx_data` stays stable. A byte moves on any clock edge where both are high. The serial side cannot be stalled. If a new byte completes while the held byte is still unread, the new byte replaces it and `rx_overrun` sets and stays set until reset.

Top module: `spi_oversampled_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_overrun` and `xfer_start` are all 0.
- R2: While `spi_cs_n` is 0, every rising edge of the sampled `spi_sclk` captures `spi_mosi`. Eight captures form one byte, first bit in bit 7. This holds for clock mode 0 (clock idles low) and clock mode 3 (clock idles high).
- R3: A rising `spi_sclk` seen while `spi_cs_n` is 1 shifts nothing. Whenever `spi_cs_n` and `spi_sclk` are both sampled high, the bit counter and shift register return to zero, so glitches before a transfer do not shift its byte alignment.
- R4: Bits of an incomplete byte are discarded when `spi_cs_n` goes high. The next transfer starts at bit 7.
- R5: `xfer_start` is a one-cycle pulse, raised exactly once for each falling edge of `spi_cs_n`, and never for clock glitches.
- R6: Bytes are received correctly with the serial clock running at one third of the system clock (high for one cycle, low for two).
- R7: A byte whose last rising clock edge comes one system cycle before `spi_cs_n` rises is still delivered.
- R8: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` is unchanged, unless a new byte completes. A byte is consumed on an edge where both are 1.
- R9: A byte that completes while `rx_valid` is 1 and `rx_ready` is 0 overwrites `rx_data` and sets `rx_overrun`. Only reset clears `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock from the master, asynchronous |
| spi_mosi | input | 1 | Serial data from the master, asynchronous |
| rx_valid | output | 1 | A received byte is held on `rx_data` |
| rx_ready | input | 1 | Consumer accepts the held byte |
| rx_data | output | 8 | Received byte |
| rx_overrun | output | 1 | Sticky: an unread byte was overwritten |
| xfer_start | output | 1 | One-cycle pulse on each chip-select falling edge |

## Verification
The assertions assume that every high and low phase of the serial clock lasts at least one system cycle. They also assume that data-in is steady across the sampled rising clock edge, so that the synchronized clock and data agree in the sampled domain. The bench drives every pin on the falling system-clock edge and never holds any clock phase shorter than one cycle. It chooses phase lengths from $urandom between one and three cycles, with a fixed one-high/two-low case for the fastest rate. Glitches are whole-cycle pulses applied only while chip-select is high.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  // Idle levels used for synchronizer and history reset values
  localparam logic CS_IDLE   = 1'b1;
  localparam logic SCLK_IDLE = 1'b0;
  localparam logic MOSI_IDLE = 1'b0;

  function automatic int unsigned cnt_bits(input int unsigned w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RST_VAL;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_front.sv
module spi_rx_front
  import spi_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,        // synchronized chip select, active low
  input  logic sclk_s,      // synchronized serial clock
  output logic sclk_rise,
  output logic cs_hi,
  output logic idle_clr,
  output logic frame_start
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= CS_IDLE;
      sclk_q <= SCLK_IDLE;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end

  assign sclk_rise   = sclk_s & ~sclk_q;
  assign cs_hi       = cs_s;
  assign idle_clr    = cs_s & sclk_s;   // spurious clock while deselected
  assign frame_start = cs_q & ~cs_s;

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  assert_start_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !cs_q);
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
  import spi_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              cs_hi,
  input  logic              idle_clr,
  input  logic              mosi_s,
  output logic              done,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned CW = cnt_bits(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shreg;
  logic              take;

  assign take = sclk_rise & ~cs_hi;
  assign done = take & (cnt == LAST);
  assign word = {shreg[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (cs_hi) begin
      cnt <= '0;
      if (idle_clr) shreg <= '0;
    end else if (take) begin
      shreg <= word;
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

  assert_glitch_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_clr |=> (cnt == '0 && shreg == '0));
  assert_partial_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> cnt == '0);
  assert_deselected_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !idle_clr) |=> $stable(shreg));
endmodule

// File: rtl/spi_rx_outbuf.sv
module spi_rx_outbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              overrun
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
    end else if (load) begin
      data  <= word;
      valid <= 1'b1;
      if (valid && !ready) overrun <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data)));
  assert_load_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(valid && !ready && load));
endmodule

// File: rtl/spi_oversampled_rx.sv
module spi_oversampled_rx
  import spi_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_overrun,
  output logic              xfer_start
);
  localparam int unsigned NPIN = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = {CS_IDLE, SCLK_IDLE, MOSI_IDLE};

  logic [NPIN-1:0] pin_raw, pin_s;
  logic sclk_rise, cs_hi, idle_clr, done;
  logic [DATA_W-1:0] word;

  assign pin_raw = {spi_cs_n, spi_sclk, spi_mosi};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    spi_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE[i])) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_raw[i]), .dout(pin_s[i]));
  end

  spi_rx_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_s(pin_s[2]), .sclk_s(pin_s[1]),
    .sclk_rise(sclk_rise), .cs_hi(cs_hi), .idle_clr(idle_clr),
    .frame_start(xfer_start));

  spi_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_hi(cs_hi),
    .idle_clr(idle_clr), .mosi_s(pin_s[0]), .done(done), .word(word));

  spi_rx_outbuf #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(done), .word(word), .ready(rx_ready),
    .valid(rx_valid), .data(rx_data), .overrun(rx_overrun));
endmodule

// File: tb/sim_spi_oversampled_rx.sv
module sim_spi_oversampled_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, rdy = 1'b0;
  logic rx_valid, rx_overrun, xfer_start;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, start_cnt = 0;
  int rdy_mode = 0;           // 0 random, 1 held low, 2 held high
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_oversampled_rx u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_mosi(mosi), .rx_valid(rx_valid), .rx_ready(rdy), .rx_data(rx_data),
    .rx_overrun(rx_overrun), .xfer_start(xfer_start));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Consumer and start-pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (xfer_start) start_cnt++;
      case (rdy_mode)
        1: rdy = 1'b0;
        2: rdy = 1'b1;
        default: rdy = ($urandom % 4) != 0;
      endcase
      if (rx_valid && rdy) begin
        if (exp_q.size() == 0)
          chk(0, "R4", "unexpected byte", rx_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R2", "received byte", rx_data, e);
        end
      end
    end
  end

  task automatic do_frame(input bit mode3, input int nbytes, input int tail,
                          input bit glitch, input bit fast, input bit late_cs);
    int s0;
    int hi, lo;
    logic [7:0] b;
    s0 = start_cnt;
    sclk = mode3; cs_n = 1'b1;
    wait_cyc(3);
    if (glitch) begin  // R3: whole-cycle pulses while deselected
      for (int g = 0; g < 2; g++) begin
        sclk = ~sclk; mosi = $urandom; wait_cyc(1);
        sclk = ~sclk; wait_cyc(2);
      end
    end
    cs_n = 1'b0;
    wait_cyc(1);
    for (int k = 0; k < nbytes + 1; k++) begin
      int nb;
      nb = (k < nbytes) ? 8 : tail;
      b = 8'($urandom);
      if (k < nbytes) exp_q.push_back(b);
      for (int i = 7; i > 7 - nb; i--) begin
        hi = fast ? 1 : 1 + int'($urandom % 3);
        lo = fast ? 2 : 2 + int'($urandom % 2);
        sclk = 1'b0; mosi = b[i]; wait_cyc(lo);
        sclk = 1'b1; wait_cyc(hi);
      end
    end
    if (late_cs) begin
      cs_n = 1'b1; sclk = mode3;     // R7: deselect right after last edge
    end else begin
      sclk = mode3; wait_cyc(1); cs_n = 1'b1;
    end
    wait_cyc(14);
    chk(start_cnt - s0 == 1, "R5", "start pulses per frame", start_cnt - s0, 1);
    if (rdy_mode != 1)
      chk(exp_q.size() == 0, late_cs ? "R7" : "R2", "bytes pending", exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    wait_cyc(4);
    chk(rx_valid == 0, "R1", "valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(rx_valid == 0, "R1", "valid after reset", rx_valid, 0);
    chk(rx_overrun == 0, "R1", "overrun after reset", rx_overrun, 0);
    chk(start_cnt == 0, "R1", "no start pulse", start_cnt, 0);

    // Directed corners
    do_frame(0, 1, 0, 0, 0, 0);            // R2 mode 0
    do_frame(1, 1, 0, 0, 0, 0);            // R2 mode 3
    do_frame(0, 2, 0, 1, 0, 0);            // R3 glitch, mode 0
    do_frame(1, 2, 0, 1, 0, 0);            // R3 glitch, mode 3
    do_frame(0, 1, 5, 0, 0, 0);            // R4 partial tail dropped
    do_frame(1, 0, 3, 1, 0, 0);            // R4 partial only
    do_frame(0, 3, 0, 0, 1, 0);            // R6 clk/3
    do_frame(1, 3, 0, 0, 1, 0);            // R6 clk/3 mode 3
    do_frame(0, 2, 0, 0, 1, 1);            // R7 late deselect
    // Random mix
    for (int r = 0; r < 30; r++)
      do_frame($urandom % 2, 1 + $urandom % 4, ($urandom % 3 == 0) ? 1 + $urandom % 7 : 0,
               $urandom % 2, $urandom % 3 == 0, $urandom % 4 == 0);
    chk(rx_overrun == 0, "R9", "no overrun under normal flow", rx_overrun, 0);

    // R8 hold under back-pressure
    rdy_mode = 1;
    do_frame(0, 1, 0, 0, 0, 0);
    wait_cyc(20);
    chk(rx_valid == 1, "R8", "valid held", rx_valid, 1);
    chk(rx_data == exp_q[0], "R8", "data held", rx_data, exp_q[0]);
    rdy_mode = 2;
    wait_cyc(3);
    chk(rx_valid == 0, "R8", "consumed", rx_valid, 0);

    // R9 overwrite
    rdy_mode = 1;
    do_frame(1, 2, 0, 0, 0, 0);
    void'(exp_q.pop_front());
    chk(rx_overrun == 1, "R9", "overrun set", rx_overrun, 1);
    chk(rx_data == exp_q[0], "R9", "newest byte kept", rx_data, exp_q[0]);
    rdy_mode = 2;
    wait_cyc(4);
    chk(exp_q.size() == 0, "R9", "drained", exp_q.size(), 0);
    chk(rx_overrun == 1, "R9", "overrun sticky", rx_overrun, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule